// File: doc/BRIEF.md
# Serial Configuration and Record Port

This block is a serial slave that sits between a host controller and a metering core. It has two jobs. In one direction it takes single-byte commands, and each command sets or clears one bit of a 112-bit configuration register. In the other direction it streams 32-bit measurement records to the host. The data line is shared: the block drives it only while a record read is running.

The direction of a transaction depends on the clock pin's level at the moment chip-select falls. A low clock level starts a command write. A high clock level starts a record read. The serial pins are resynchronised into the system clock, so the serial clock must be much slower than the system clock.

Records come from a parallel payload bus. Each record has 28 payload bits. The block computes 4 parity bits for it at the moment the record is loaded into the shift register. The records form groups of four, and a read walks through all of them in index order.

Top module: `spiCfgPort`

## Requirements
- R1: After reset, every configuration bit is 0, the data line is not driven (`sdaOe` = 0) and `recIdx` is 0.
- R2: A write transaction starts when chip-select falls while the clock pin is low. Command bits are sampled on rising clock edges, most significant bit first. In the completed 8-bit command, bit 7 is the value and bits 6:0 are the configuration bit address. When the eighth bit arrives, `cfg[address]` takes that value and no other configuration bit changes.
- R3: A command whose address is in the range 112 to 127 leaves the whole configuration register unchanged.
- R4: Several command bytes sent back to back inside one chip-select window are each applied, in order.
- R5: If chip-select rises before the eighth bit of a command, the partial command is discarded. The next transaction starts counting bits afresh.
- R6: During a write transaction the block never drives the data line (`sdaOe` stays 0).
- R7: A read transaction starts when chip-select falls while the clock pin is high. Record 0 is loaded and its bit 0 appears on `sdaOut`. After each rising clock edge the next bit appears, so the record goes out least significant bit first and therefore least significant byte first. After 32 rising edges the next record is loaded.
- R8: A shifted record carries the payload in bits 27:0 and parity in bits 31:28. Parity bit k is the XOR of every payload bit whose index modulo 4 equals k.
- R9: Record r, where r = group*4 + position, is taken from `recPayload[r*28 +: 28]`. Records are read in increasing index and wrap to 0 after the last one. Every load pulses `recLoad` for one cycle, and `recIdx` then holds the index of the loaded record.
- R10: `sdaOe` is high for the whole of a read transaction and returns low after chip-select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial bit clock; its level at chip-select fall selects read or write |
| sdaIn | input | 1 | Data line as seen at the pad (command bits) |
| sdaOut | output | 1 | Record bit driven to the data line |
| sdaOe | output | 1 | Output enable for the data line pad |
| recPayload | input | NUM_GROUPS*4*28 | Parallel payload of all records |
| cfg | output | CFG_BITS | Configuration register |
| recLoad | output | 1 | One-cycle strobe when a record is captured |
| recIdx | output | $clog2(NUM_GROUPS*4) | Index of the record most recently captured |

## Verification
The bench sends random commands mixed with commands aimed at addresses 111, 112 and 127. The high addresses catch a range check that is off by one or missing; such a bug would corrupt some other configuration bit. Chip-select is also cut part way through a byte. A design that kept its bit count across transactions would then misalign every later command. Record reads run past the last record, which exposes a missing wrap or a wrong payload slice. Each received word is compared with an independently computed parity nibble, so a reversed bit order or a wrong parity lane shows up as a mismatched word.

// File: rtl/spiCfgPkg.sv
package spiCfgPkg;
  localparam int REC_W      = 32;
  localparam int PAR_W      = 4;
  localparam int PAY_W      = REC_W - PAR_W;
  localparam int GROUP_SIZE = 4;
  localparam int CMD_W      = 8;
  localparam int ADDR_W     = CMD_W - 1;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2
  } portModeT;

  typedef struct packed {
    logic shiftIn;
    logic cmdDone;
    logic loadRec;
    logic shiftOut;
  } spiStrobeT;

  // Append the parity nibble: lane k covers payload bits with index mod 4 == k
  function automatic logic [REC_W-1:0] sealRecord(input logic [PAY_W-1:0] payload);
    logic [PAR_W-1:0] par;
    par = '0;
    for (int i = 0; i < PAY_W; i++) begin
      par[i % PAR_W] = par[i % PAR_W] ^ payload[i];
    end
    return {par, payload};
  endfunction
endpackage

// File: rtl/spiCfgCtrl.sv
module spiCfgCtrl
  import spiCfgPkg::*;
#(
  parameter int NUM_REC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdaIn,
  output spiStrobeT        strb,
  output logic [IDX_W-1:0] loadIdx,
  output logic [IDX_W-1:0] recIdx,
  output logic             sdiS,
  output logic             sdaOe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REC - 1);

  logic csMeta, csS, csD;
  logic sclkMeta, sclkS, sclkD;
  logic sdiMeta;
  portModeT mode;
  logic [4:0] bitCnt;
  logic csFall, sclkRise, active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta <= 1'b1; csS <= 1'b1; csD <= 1'b1;
      sclkMeta <= 1'b0; sclkS <= 1'b0; sclkD <= 1'b0;
      sdiMeta <= 1'b0; sdiS <= 1'b0;
    end else begin
      csMeta <= csN;    csS <= csMeta;    csD <= csS;
      sclkMeta <= sclk; sclkS <= sclkMeta; sclkD <= sclkS;
      sdiMeta <= sdaIn; sdiS <= sdiMeta;
    end
  end

  assign csFall   = csD & ~csS;
  assign sclkRise = sclkS & ~sclkD;
  assign active   = ~csS;

  always_comb begin
    strb    = '0;
    loadIdx = recIdx;
    if (csFall && sclkS) begin
      strb.loadRec = 1'b1;
      loadIdx      = '0;
    end else if (active && sclkRise && mode == MODE_WRITE) begin
      strb.shiftIn = 1'b1;
      strb.cmdDone = (bitCnt[2:0] == 3'd7);
    end else if (active && sclkRise && mode == MODE_READ) begin
      if (bitCnt == 5'd31) begin
        strb.loadRec = 1'b1;
        loadIdx      = (recIdx == LAST_IDX) ? '0 : recIdx + 1'b1;
      end else begin
        strb.shiftOut = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_IDLE;
      bitCnt <= '0;
      recIdx <= '0;
    end else begin
      if (csS)         mode <= MODE_IDLE;
      else if (csFall) mode <= sclkS ? MODE_READ : MODE_WRITE;
      if (csFall) bitCnt <= '0;
      else if (strb.shiftIn || strb.shiftOut || (strb.loadRec && mode == MODE_READ))
        bitCnt <= bitCnt + 1'b1;
      if (strb.loadRec) recIdx <= loadIdx;
    end
  end

  assign sdaOe = (mode == MODE_READ);

  a_r7_first_record_on_select: assert property (@(posedge clk) disable iff (!rstN)
    (csFall && sclkS) |-> (strb.loadRec && loadIdx == '0));
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.loadRec, strb.shiftOut}));
  a_r9_index_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRec && mode == MODE_READ && !csFall && recIdx == LAST_IDX) |=> (recIdx == '0));
  a_r10_release_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !sdaOe);
endmodule

// File: rtl/spiCfgDatapath.sv
module spiCfgDatapath
  import spiCfgPkg::*;
#(
  parameter int CFG_BITS = 112,
  parameter int NUM_REC  = 8,
  parameter int IDX_W    = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  spiStrobeT                strb,
  input  logic                     sdiS,
  input  logic [IDX_W-1:0]         loadIdx,
  input  logic [NUM_REC*PAY_W-1:0] recPayload,
  output logic [CFG_BITS-1:0]      cfg,
  output logic                     sdaOut
);
  logic [CMD_W-2:0]  cmdSh;
  logic [CMD_W-1:0]  cmdByte;
  logic [ADDR_W-1:0] cmdAddr;
  logic              addrOk;
  logic [REC_W-1:0]  recSh;

  assign cmdByte = {cmdSh, sdiS};
  assign cmdAddr = cmdByte[ADDR_W-1:0];
  assign addrOk  = (32'(cmdAddr) < CFG_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh <= '0;
      cfg   <= '0;
      recSh <= '0;
    end else begin
      if (strb.shiftIn) cmdSh <= cmdByte[CMD_W-2:0];
      if (strb.cmdDone && addrOk) cfg[cmdAddr] <= cmdByte[CMD_W-1];
      if (strb.loadRec)
        recSh <= sealRecord(recPayload[32'(loadIdx)*PAY_W +: PAY_W]);
      else if (strb.shiftOut)
        recSh <= {1'b0, recSh[REC_W-1:1]};
    end
  end

  assign sdaOut = recSh[0];

  a_r3_high_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdDone && cmdAddr >= ADDR_W'(CFG_BITS)) |=> $stable(cfg));
  a_r2_one_bit_per_cmd: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdDone |=> ($countones(cfg ^ $past(cfg)) <= 1));
  a_r2_quiet_without_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmdDone |=> $stable(cfg));
  a_r2_value_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdDone && addrOk) |=> (cfg[$past(cmdAddr)] == $past(cmdByte[CMD_W-1])));
endmodule

// File: rtl/spiCfgPort.sv
module spiCfgPort
  import spiCfgPkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int CFG_BITS   = 112,
  localparam int NUM_REC   = NUM_GROUPS * GROUP_SIZE,
  localparam int IDX_W     = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     sdaIn,
  output logic                     sdaOut,
  output logic                     sdaOe,
  input  logic [NUM_REC*PAY_W-1:0] recPayload,
  output logic [CFG_BITS-1:0]      cfg,
  output logic                     recLoad,
  output logic [IDX_W-1:0]         recIdx
);
  spiStrobeT        strb;
  logic [IDX_W-1:0] loadIdx;
  logic             sdiS;

  spiCfgCtrl #(.NUM_REC(NUM_REC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdaIn(sdaIn),
    .strb(strb), .loadIdx(loadIdx), .recIdx(recIdx), .sdiS(sdiS), .sdaOe(sdaOe)
  );

  spiCfgDatapath #(.CFG_BITS(CFG_BITS), .NUM_REC(NUM_REC), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS), .loadIdx(loadIdx),
    .recPayload(recPayload), .cfg(cfg), .sdaOut(sdaOut)
  );

  assign recLoad = strb.loadRec;
endmodule

// File: tb/test_spiCfgPort.sv
module test_spiCfgPort;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREC       = 8;
  localparam int PW         = 28;
  localparam int CB         = 112;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdaIn = 1'b0;
  logic sdaOut, sdaOe, recLoad;
  logic [NREC*PW-1:0] recPayload = '0;
  logic [CB-1:0] cfg;
  logic [2:0] recIdx;
  logic [CB-1:0] model = '0;
  int checks = 0, errors = 0, loadCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (recLoad) loadCnt++;

  spiCfgPort i_spiCfgPort (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .recPayload(recPayload), .cfg(cfg),
    .recLoad(recLoad), .recIdx(recIdx)
  );

  function automatic logic [31:0] expRecord(input logic [PW-1:0] p);
    logic [3:0] par;
    for (int k = 0; k < 4; k++) begin
      logic [PW-1:0] mask;
      mask = '0;
      for (int j = k; j < PW; j += 4) mask[j] = 1'b1;
      par[k] = ^(p & mask);
    end
    return {par, p};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdaIn = b[i]; waitClk(HALF);
      sclk = 1'b1;  waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic applyModel(input logic [7:0] b);
    if (b[6:0] < CB) model[b[6:0]] = b[7];
  endtask

  task automatic writeByte(input logic [7:0] b);
    sclk = 1'b0; waitClk(HALF);
    csN = 1'b0;  waitClk(HALF);
    sendBits(b, 8);
    chk("R6 no drive in write", {127'd0, sdaOe}, 128'd0);
    csN = 1'b1;  waitClk(HALF);
    applyModel(b);
  endtask

  task automatic readRecords(input int n);
    int startCnt;
    startCnt = loadCnt;
    sclk = 1'b1; waitClk(HALF);
    csN = 1'b0;  waitClk(HALF);
    chk("R10 drive during read", {127'd0, sdaOe}, 128'd1);
    for (int r = 0; r < n; r++) begin
      logic [31:0] word;
      chk("R9 record index", {125'd0, recIdx}, 128'(r % NREC));
      for (int b = 0; b < 32; b++) begin
        word[b] = sdaOut;
        sclk = 1'b0; waitClk(HALF);
        sclk = 1'b1; waitClk(HALF);
      end
      chk("R7 R8 record word", {96'd0, word},
          {96'd0, expRecord(recPayload[(r % NREC)*PW +: PW])});
    end
    chk("R9 load strobes", 128'(loadCnt - startCnt), 128'(n + 1));
    csN = 1'b1; waitClk(HALF);
    chk("R10 release after read", {127'd0, sdaOe}, 128'd0);
    sclk = 1'b0; waitClk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    waitClk(4);
    chk("R1 cfg reset", {16'd0, cfg}, 128'd0);
    chk("R1 oe reset", {127'd0, sdaOe}, 128'd0);
    chk("R1 idx reset", {125'd0, recIdx}, 128'd0);
    rstN = 1'b1;
    waitClk(4);

    // R2 directed edges of address space
    writeByte(8'h80); chk("R2 set addr 0", {16'd0, cfg}, {16'd0, model});
    writeByte(8'hEF); chk("R2 set addr 111", {16'd0, cfg}, {16'd0, model});
    // R3 out of range addresses
    writeByte(8'hF0); chk("R3 addr 112 ignored", {16'd0, cfg}, {16'd0, model});
    writeByte(8'hFF); chk("R3 addr 127 ignored", {16'd0, cfg}, {16'd0, model});
    writeByte(8'h00); chk("R2 clear addr 0", {16'd0, cfg}, {16'd0, model});

    // R5 partial byte discarded, then fresh command aligns
    sclk = 1'b0; waitClk(HALF); csN = 1'b0; waitClk(HALF);
    sendBits(8'hA5, 5);
    csN = 1'b1; waitClk(HALF);
    chk("R5 partial discarded", {16'd0, cfg}, {16'd0, model});
    writeByte(8'hA5); chk("R5 next byte aligned", {16'd0, cfg}, {16'd0, model});

    // R4 several bytes in one window
    begin
      logic [7:0] seq [3];
      seq[0] = 8'h8A; seq[1] = 8'hB7; seq[2] = 8'h0A;
      sclk = 1'b0; waitClk(HALF); csN = 1'b0; waitClk(HALF);
      for (int i = 0; i < 3; i++) begin
        sendBits(seq[i], 8);
        applyModel(seq[i]);
      end
      csN = 1'b1; waitClk(HALF);
      chk("R4 burst of commands", {16'd0, cfg}, {16'd0, model});
    end

    // R2 R3 random commands
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      writeByte(b);
      chk("R2 R3 random command", {16'd0, cfg}, {16'd0, model});
    end

    // R7 R8 R9 record reads with wrap
    for (int r = 0; r < NREC; r++) recPayload[r*PW +: PW] = PW'($urandom);
    recPayload[0 +: PW] = '1;
    readRecords(NREC + 1);
    for (int r = 0; r < NREC; r++) recPayload[r*PW +: PW] = PW'($urandom);
    readRecords(2);

    chk("R6 cfg intact after reads", {16'd0, cfg}, {16'd0, model});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule